// File: doc/BRIEF.md
# Request-Acknowledge Window Checker

This block is a synthesizable protocol monitor meant to live inside a design running on a prototype board. It watches a trigger input, typically a bus request. When the trigger is sampled high, it opens a timing window and expects a response input, typically an acknowledge, to arrive no sooner than `MIN` and no later than `MAX` clocks after the trigger. A response that comes too soon raises an early-response failure. A response that never comes raises a late-response failure. A response inside the bounds closes the window as a pass. Because the flag is raised on the clock where the rule breaks, a fault is localized in both place and time, not left to surface at the chip's outputs much later.

Each failure is reported in four ways:
- a one-cycle flag,
- a two-bit failure-kind code,
- a severity code fixed by a parameter,
- a sticky error bit.

Each passing window gives a one-cycle coverage pulse. Two saturating counters tally failures and passes. Only one window is tracked at a time.

The control is a two-state machine with states `W_IDLE` and `W_OPEN`. Its transitions are:
- `T_ARM`: `W_IDLE`→`W_OPEN` on a trigger without a decided outcome.
- `T_INSTANT`: stays in `W_IDLE` when a trigger and a response share a cycle, or when `MAX`=0.
- `T_STEP`: stays in `W_OPEN` while the count advances.
- `T_ACCEPT`, `T_EARLY`, `T_LATE`: each returns `W_OPEN`→`W_IDLE`.

A configuration with `MIN` > `MAX` stops elaboration.

Top module: `reqack_window_checker`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state clears the machine to `W_IDLE`. It also drives `fail_o`, `pass_o`, `fail_kind_o`, `sev_o`, `err_sticky_o`, `fail_cnt_o` and `pass_cnt_o` to zero.
- R2: After a trigger sampled in `W_IDLE`, the window count is 1 on the next sampled cycle and rises by one per clock. A response sampled while the count is in [`MIN`,`MAX`] produces `pass_o` high for exactly the cycle after that edge, and closes the window.
- R3: A response sampled while the count is below `MIN` produces a one-cycle `fail_o` with `fail_kind_o` = 2'b01 (early). This includes a response in the trigger's own cycle when `MIN` > 0. `fail_o` and `pass_o` are never high together.
- R4: If no response is sampled up to and including the cycle where the count equals `MAX`, the edge that samples that cycle raises a one-cycle `fail_o` with `fail_kind_o` = 2'b10 (late).
- R5: `sev_o` equals the `SEVERITY` parameter whenever `fail_o` is high. When `fail_o` is low, `sev_o` and `fail_kind_o` are zero.
- R6: A trigger sampled while a window is open is ignored. The count neither restarts nor is a second window queued.
- R7: A response sampled in `W_IDLE` without a trigger is ignored and produces no pulse.
- R8: `err_sticky_o` goes high on the clock after the first `fail_o` pulse. It stays high until reset.
- R9: `fail_cnt_o` and `pass_cnt_o` each rise by one on the clock after a `fail_o` or `pass_o` pulse. They saturate at 2^`CNT_W`−1.
- R10: With `MIN` = 0, a response in the same cycle as the trigger is a pass, and the machine stays in `W_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Trigger that opens a window |
| resp_i | input | 1 | Response being timed |
| fail_o | output | 1 | One-cycle failure flag |
| pass_o | output | 1 | One-cycle coverage pulse for a good window |
| fail_kind_o | output | 2 | 01 early, 10 late, 00 otherwise |
| sev_o | output | SEV_W | Severity code during a failure |
| err_sticky_o | output | 1 | Set by any failure, cleared by reset |
| fail_cnt_o | output | CNT_W | Saturating failure tally |
| pass_cnt_o | output | CNT_W | Saturating pass tally |

## Verification
The embedded properties assume `start_i` and `resp_i` are synchronous to `clk`. They also assume the inputs hold a defined value at every edge after reset, since the machine treats any sampled level as a real event. The stimulus changes both inputs only on falling edges. It drives them from known values, both in directed sweeps of the response delay from 0 to beyond `MAX` and in a random phase. It also runs a long phase with both inputs held high, which drives the counters into saturation.

// File: rtl/rawc_pkg.sv
package rawc_pkg;
    typedef enum logic {
        W_IDLE = 1'b0,
        W_OPEN = 1'b1
    } win_state_t;

    typedef enum logic [1:0] {
        FK_NONE  = 2'b00,
        FK_EARLY = 2'b01,
        FK_LATE  = 2'b10
    } fail_kind_t;
endpackage

// File: rtl/rawc_sat_counter.sv
module rawc_sat_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] q_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (inc_i && (q_o != TOP))
            q_o <= q_o + 1'b1;
    end

    assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o == TOP) |=> (q_o == TOP));
    assert_sat_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && q_o != TOP) |=> (q_o == $past(q_o) + 1'b1));
endmodule

// File: rtl/rawc_window_fsm.sv
module rawc_window_fsm
    import rawc_pkg::*;
#(
    parameter int unsigned MIN = 3,
    parameter int unsigned MAX = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       resp_i,
    output logic       pass_o,
    output logic       fail_o,
    output logic [1:0] kind_o
);
    localparam int unsigned CW = $clog2(MAX + 2);
    localparam logic [CW-1:0] MIN_C = CW'(MIN);
    localparam logic [CW-1:0] MAX_C = CW'(MAX);

    win_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pass_d, fail_d;
    fail_kind_t    kind_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pass_d  = 1'b0;
        fail_d  = 1'b0;
        kind_d  = FK_NONE;
        unique case (state_q)
            W_IDLE: begin
                if (start_i) begin
                    if (resp_i) begin
                        if (MIN == 0) begin
                            pass_d = 1'b1;
                        end else begin
                            fail_d = 1'b1;
                            kind_d = FK_EARLY;
                        end
                    end else if (MAX == 0) begin
                        fail_d = 1'b1;
                        kind_d = FK_LATE;
                    end else begin
                        state_d = W_OPEN;
                        cnt_d   = CW'(1);
                    end
                end
            end
            W_OPEN: begin
                if (resp_i) begin
                    state_d = W_IDLE;
                    if (cnt_q < MIN_C) begin
                        fail_d = 1'b1;
                        kind_d = FK_EARLY;
                    end else begin
                        pass_d = 1'b1;
                    end
                end else if (cnt_q >= MAX_C) begin
                    state_d = W_IDLE;
                    fail_d  = 1'b1;
                    kind_d  = FK_LATE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_o <= 1'b0;
            fail_o <= 1'b0;
            kind_o <= FK_NONE;
        end else begin
            pass_o <= pass_d;
            fail_o <= fail_d;
            kind_o <= kind_d;
        end
    end

    assert_cnt_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_OPEN) |-> (cnt_q >= CW'(1) && cnt_q <= MAX_C));
    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_OPEN && !resp_i && cnt_q < MAX_C)
            |=> (state_q == W_OPEN && cnt_q == $past(cnt_q) + 1'b1));
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_IDLE && !start_i) |=> (!pass_o && !fail_o && state_q == W_IDLE));
    assert_pass_fail_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));
endmodule

// File: rtl/reqack_window_checker.sv
module reqack_window_checker #(
    parameter int unsigned MIN      = 3,
    parameter int unsigned MAX      = 6,
    parameter int unsigned SEV_W    = 3,
    parameter int unsigned SEVERITY = 2,
    parameter int unsigned CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             resp_i,
    output logic             fail_o,
    output logic             pass_o,
    output logic [1:0]       fail_kind_o,
    output logic [SEV_W-1:0] sev_o,
    output logic             err_sticky_o,
    output logic [CNT_W-1:0] fail_cnt_o,
    output logic [CNT_W-1:0] pass_cnt_o
);
    localparam int unsigned NCNT = 2;

    generate
        if (MIN > MAX) begin : g_bad_window
            $error("window lower bound exceeds upper bound");
        end
    endgenerate

    logic             fail_w, pass_w;
    logic [1:0]       kind_w;
    logic [NCNT-1:0]  inc_v;
    logic [CNT_W-1:0] cnt_v [NCNT];

    rawc_window_fsm #(.MIN(MIN), .MAX(MAX)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .resp_i  (resp_i),
        .pass_o  (pass_w),
        .fail_o  (fail_w),
        .kind_o  (kind_w)
    );

    assign inc_v = {pass_w, fail_w};

    for (genvar g = 0; g < NCNT; g++) begin : g_tally
        rawc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (inc_v[g]),
            .q_o   (cnt_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            err_sticky_o <= 1'b0;
        else if (fail_w)
            err_sticky_o <= 1'b1;
    end

    assign fail_o      = fail_w;
    assign pass_o      = pass_w;
    assign fail_kind_o = kind_w;
    assign sev_o       = fail_w ? SEV_W'(SEVERITY) : '0;
    assign fail_cnt_o  = cnt_v[0];
    assign pass_cnt_o  = cnt_v[1];

    assert_kind_coded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (fail_kind_o == 2'b01 || fail_kind_o == 2'b10));
    assert_quiet_codes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fail_o |-> (fail_kind_o == 2'b00 && sev_o == '0));
    assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky_o |=> err_sticky_o);
    assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> err_sticky_o);
endmodule

// File: tb/test_reqack_window_checker.sv
module test_reqack_window_checker;
    localparam int NI = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st = 1'b0;
    logic rs = 1'b0;

    always #10 clk = ~clk;

    logic        f0, p0, s0, f1, p1, s1;
    logic [1:0]  k0, k1;
    logic [2:0]  v0, v1;
    logic [15:0] fc0, pc0;
    logic [3:0]  fc1, pc1;

    reqack_window_checker i_reqack_window_checker (
        .clk(clk), .rst_n(rst_n), .start_i(st), .resp_i(rs),
        .fail_o(f0), .pass_o(p0), .fail_kind_o(k0), .sev_o(v0),
        .err_sticky_o(s0), .fail_cnt_o(fc0), .pass_cnt_o(pc0)
    );

    reqack_window_checker #(.MIN(0), .MAX(2), .SEV_W(3), .SEVERITY(5), .CNT_W(4))
        i_reqack_window_checker_min0 (
        .clk(clk), .rst_n(rst_n), .start_i(st), .resp_i(rs),
        .fail_o(f1), .pass_o(p1), .fail_kind_o(k1), .sev_o(v1),
        .err_sticky_o(s1), .fail_cnt_o(fc1), .pass_cnt_o(pc1)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    int p_min [NI] = '{3, 0};
    int p_max [NI] = '{6, 2};
    int p_sev [NI] = '{2, 5};
    int p_top [NI] = '{65535, 15};

    int m_open [NI];
    int m_cnt  [NI];
    int m_fail [NI];
    int m_pass [NI];
    int m_kind [NI];
    int m_stk  [NI];
    int m_fc   [NI];
    int m_pc   [NI];

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        for (int i = 0; i < NI; i++) begin
            if (!rst_n) begin
                m_open[i] = 0; m_cnt[i] = 0; m_fail[i] = 0; m_pass[i] = 0;
                m_kind[i] = 0; m_stk[i] = 0; m_fc[i] = 0; m_pc[i] = 0;
            end else begin
                if (m_fail[i] != 0) begin
                    m_stk[i] = 1;
                    if (m_fc[i] < p_top[i]) m_fc[i]++;
                end
                if (m_pass[i] != 0 && m_pc[i] < p_top[i]) m_pc[i]++;
                m_fail[i] = 0; m_pass[i] = 0; m_kind[i] = 0;
                if (m_open[i] == 0) begin
                    if (st) begin
                        if (rs) begin
                            if (p_min[i] == 0) m_pass[i] = 1;
                            else begin m_fail[i] = 1; m_kind[i] = 1; end
                        end else begin
                            m_open[i] = 1; m_cnt[i] = 1;
                        end
                    end
                end else if (rs) begin
                    m_open[i] = 0;
                    if (m_cnt[i] < p_min[i]) begin m_fail[i] = 1; m_kind[i] = 1; end
                    else m_pass[i] = 1;
                end else if (m_cnt[i] >= p_max[i]) begin
                    m_open[i] = 0; m_fail[i] = 1; m_kind[i] = 2;
                end else begin
                    m_cnt[i]++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cyc > 0) begin
            cmp("R2", "pass_o[0]", int'(p0), m_pass[0]);
            cmp("R3", "fail_o[0]", int'(f0), m_fail[0]);
            cmp("R4", "kind[0]", int'(k0), m_kind[0] == 1 ? 1 : (m_kind[0] == 2 ? 2 : 0));
            cmp("R5", "sev[0]", int'(v0), m_fail[0] != 0 ? p_sev[0] : 0);
            cmp("R8", "sticky[0]", int'(s0), m_stk[0]);
            cmp("R9", "fail_cnt[0]", int'(fc0), m_fc[0]);
            cmp("R9", "pass_cnt[0]", int'(pc0), m_pc[0]);
            cmp("R10", "pass_o[1]", int'(p1), m_pass[1]);
            cmp("R3", "fail_o[1]", int'(f1), m_fail[1]);
            cmp("R4", "kind[1]", int'(k1), m_kind[1]);
            cmp("R5", "sev[1]", int'(v1), m_fail[1] != 0 ? p_sev[1] : 0);
            cmp("R8", "sticky[1]", int'(s1), m_stk[1]);
            cmp("R9", "fail_cnt[1]", int'(fc1), m_fc[1]);
            cmp("R9", "pass_cnt[1]", int'(pc1), m_pc[1]);
        end
    end

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            st = 1'b0; rs = 1'b0;
        end
    endtask

    task automatic check_cleared(input string tag);
        cmp(tag, "fail_o", int'(f0), 0);
        cmp(tag, "pass_o", int'(p0), 0);
        cmp(tag, "sticky", int'(s0), 0);
        cmp(tag, "fail_cnt", int'(fc0), 0);
        cmp(tag, "pass_cnt", int'(pc0), 0);
        cmp(tag, "pass_cnt_min0", int'(pc1), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_cleared("R1");

        // R2 R3 R4 R10: sweep response delay from the trigger cycle past MAX
        for (int k = 0; k <= 8; k++) begin
            @(negedge clk);
            st = 1'b1; rs = (k == 0);
            if (k == 0) begin
                @(negedge clk);
                st = 1'b0; rs = 1'b0;
                cmp("R10", "same-cycle pass min0", int'(p1), 1);
                cmp("R3", "same-cycle early", int'(k0), 1);
            end else begin
                for (int j = 1; j < k; j++) begin
                    @(negedge clk);
                    st = 1'b0; rs = 1'b0;
                end
                @(negedge clk);
                st = 1'b0; rs = 1'b1;
            end
            idle(10);
        end

        // R7: response with no trigger in idle
        @(negedge clk);
        rs = 1'b1;
        @(negedge clk);
        rs = 1'b0;
        cmp("R7", "idle response no pulse", int'(p0 | f0), 0);
        idle(3);

        // R6: repeated triggers inside an open window do not restart it
        @(negedge clk);
        st = 1'b1; rs = 1'b0;
        for (int j = 1; j < 4; j++) begin
            @(negedge clk);
            st = 1'b1; rs = 1'b0;
        end
        @(negedge clk);
        st = 1'b1; rs = 1'b1;
        @(negedge clk);
        st = 1'b0; rs = 1'b0;
        cmp("R6", "retrigger ignored pass", int'(p0), 1);
        idle(8);

        // random traffic
        for (int j = 0; j < 3000; j++) begin
            @(negedge clk);
            st = ($urandom_range(0, 3) == 0);
            rs = ($urandom_range(0, 4) == 0);
        end
        idle(10);

        // R9: flood to saturate both tallies
        for (int j = 0; j < 65545; j++) begin
            @(negedge clk);
            st = 1'b1; rs = 1'b1;
        end
        idle(3);
        cmp("R9", "fail_cnt saturated", int'(fc0), 65535);
        cmp("R9", "pass_cnt min0 saturated", int'(pc1), 15);

        // R1 R8: reset clears sticky and tallies
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        check_cleared("R8");
        idle(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule